// File: doc/BRIEF.md
# Two-Master Word-Collision SRAM Arbiter

This block lets a processor port and a DMA port share one 64-bit-wide SRAM. The array is modelled with two access ports, so the two masters proceed side by side whenever they touch different 64-bit words. They also proceed together when both only read. A hold-off happens only when both masters present an access to the same word in the same clock and at least one of them writes.

On such a collision the write is taken first. The losing master has its ready signal held low for one clock, and it is served in the next clock. A read that was held back therefore returns the word with the write already merged in. When both masters write the same word, the DMA write lands first and the processor write follows. Byte lanes enabled by both writes end up with the processor's data.

Accesses are accepted in the clock in which ready is high. Writes take effect at that clock edge. Read data comes back one clock later, marked by a valid pulse.

Top module: `dual_master_word_arb`

## Requirements
- R1: Two accesses target the same word exactly when their byte addresses match above bit 2. Addresses that differ only in bits 2:0 collide. Addresses that differ by 8 do not collide.
- R2: When both ports request in one cycle and either the words differ or both are reads, both ready outputs are high in that cycle. Requests in different cycles never hold each other off.
- R3: When a read and a write from the two ports hit the same word in one cycle, and neither port is carrying over a hold-off, the writer's ready is high and the reader's ready is low.
- R4: A port whose ready was low while it requested is granted in the next cycle if it keeps its request unchanged. A held-back read returns the word including the write that beat it.
- R5: When both ports write the same word in one cycle, the DMA port is granted first and the processor port one cycle later. On byte lanes enabled by both, the processor's data remains.
- R6: A granted read raises the port's rvalid in the next cycle, with that word's contents as of before the grant edge. A granted write updates only the byte lanes whose strobe bit is set, where strobe bit i covers data bits 8i+7 to 8i. No rvalid appears without a granted read.
- R7: A ready output is high only while its port requests. During reset, ready and rvalid are low.
- R8: In the cycle after a hold-off, the held-back port is granted even if the other port presents a new colliding access. That other access is then held back for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Processor access request |
| cpuWe | input | 1 | Processor write (1) or read (0) |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuBe | input | DATA_W/8 | Processor byte-lane strobes |
| cpuReady | output | 1 | Processor access accepted this cycle |
| cpuRvalid | output | 1 | Processor read data valid |
| cpuRdata | output | DATA_W | Processor read data |
| dmaReq | input | 1 | DMA access request |
| dmaWe | input | 1 | DMA write (1) or read (0) |
| dmaAddr | input | ADDR_W | DMA byte address |
| dmaWdata | input | DATA_W | DMA write data |
| dmaBe | input | DATA_W/8 | DMA byte-lane strobes |
| dmaReady | output | 1 | DMA access accepted this cycle |
| dmaRvalid | output | 1 | DMA read data valid |
| dmaRdata | output | DATA_W | DMA read data |

## Verification
The bench drives several pairs of accesses in the same cycle:
- different words with both reads, both writes, and a read beside a write;
- neighbouring words 8 bytes apart, which separate word-level from finer detection;
- addresses inside one word that differ only in their low bits, which must still collide;
- read against write in both directions, which shows that the write goes first regardless of which port writes;
- a double write with overlapping strobes, which exposes the DMA-then-processor order through the merged bytes;
- a held-back port facing a fresh colliding access, which separates carried-over priority from the plain write-first rule.

A shadow memory predicts every returned word, so a read served before the write that beat it is reported as a data mismatch.

// File: rtl/word_arb_pkg.sv
package word_arb_pkg;

  localparam int PORTS   = 2;
  localparam int CPU_IDX = 0;
  localparam int DMA_IDX = 1;

  // Strobes from control to datapath: which port is served this cycle.
  typedef struct packed {
    logic dmaGo;
    logic cpuGo;
  } grant_t;

endpackage

// File: rtl/word_arb_ctrl.sv
module word_arb_ctrl import word_arb_pkg::*; #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [WORD_W-1:0] cpuWord,
  input  logic              dmaReq,
  input  logic              dmaWe,
  input  logic [WORD_W-1:0] dmaWord,
  output grant_t            grant
);

  logic sameWord;
  logic clash;
  logic pendCpu, pendDma;

  assign sameWord = (cpuWord == dmaWord);
  assign clash    = cpuReq && dmaReq && sameWord && (cpuWe || dmaWe);

  // Priority on a clash: carried-over hold-off, then the write, then DMA.
  always_comb begin
    grant.cpuGo = cpuReq;
    grant.dmaGo = dmaReq;
    if (clash) begin
      if (pendCpu) begin
        grant.dmaGo = 1'b0;
      end else if (pendDma) begin
        grant.cpuGo = 1'b0;
      end else if (dmaWe) begin
        grant.cpuGo = 1'b0;
      end else begin
        grant.dmaGo = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCpu <= 1'b0;
      pendDma <= 1'b0;
    end else begin
      pendCpu <= cpuReq && !grant.cpuGo;
      pendDma <= dmaReq && !grant.dmaGo;
    end
  end

  // R4
  cpu_stall_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !grant.cpuGo) |=> (grant.cpuGo || !cpuReq));

  // R4
  dma_stall_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !grant.dmaGo) |=> (grant.dmaGo || !dmaReq));

  // R7
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant.cpuGo |-> cpuReq) and (grant.dmaGo |-> dmaReq));

  // R2
  free_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && dmaReq && (!sameWord || (!cpuWe && !dmaWe)))
      |-> (grant.cpuGo && grant.dmaGo));

  // R3
  clash_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    clash |-> ($countones({grant.cpuGo, grant.dmaGo}) == 1));

  // R8
  pend_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && dmaReq && !grant.cpuGo) |=> (cpuReq -> grant.cpuGo));

endmodule

// File: rtl/word_arb_dpath.sv
module word_arb_dpath import word_arb_pkg::*; #(
  parameter int WORD_W = 9,
  parameter int DATA_W = 64,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  grant_t                        grant,
  input  logic [PORTS-1:0]              portWe,
  input  logic [PORTS-1:0][WORD_W-1:0]  portWord,
  input  logic [PORTS-1:0][DATA_W-1:0]  portWdata,
  input  logic [PORTS-1:0][STRB_W-1:0]  portBe,
  output logic [PORTS-1:0]              portRvalid,
  output logic [PORTS-1:0][DATA_W-1:0]  portRdata
);

  localparam int DEPTH = 1 << WORD_W;

  logic [PORTS-1:0]  portGo;
  logic [DATA_W-1:0] mem [DEPTH];

  always_comb begin
    portGo          = '0;
    portGo[CPU_IDX] = grant.cpuGo;
    portGo[DMA_IDX] = grant.dmaGo;
  end

  // Two write ports; the control never grants two writes to one word.
  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (portGo[p] && portWe[p]) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (portBe[p][b]) begin
            mem[portWord[p]][b*8 +: 8] <= portWdata[p][b*8 +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (portGo[p] && !portWe[p]) begin
        portRdata[p] <= mem[portWord[p]];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portRvalid <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        portRvalid[p] <= portGo[p] && !portWe[p];
      end
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_portChk
      // R6
      rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
        (portGo[p] && !portWe[p]) |=> portRvalid[p]);
      // R6
      no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(portGo[p] && !portWe[p]) |=> !portRvalid[p]);
    end
  endgenerate

endmodule

// File: rtl/dual_master_word_arb.sv
module dual_master_word_arb import word_arb_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuReq,
  input  logic                  cpuWe,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [DATA_W/8-1:0]   cpuBe,
  output logic                  cpuReady,
  output logic                  cpuRvalid,
  output logic [DATA_W-1:0]     cpuRdata,
  input  logic                  dmaReq,
  input  logic                  dmaWe,
  input  logic [ADDR_W-1:0]     dmaAddr,
  input  logic [DATA_W-1:0]     dmaWdata,
  input  logic [DATA_W/8-1:0]   dmaBe,
  output logic                  dmaReady,
  output logic                  dmaRvalid,
  output logic [DATA_W-1:0]     dmaRdata
);

  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(STRB_W);
  localparam int WORD_W = ADDR_W - OFF_W;

  grant_t                        grant;
  logic [WORD_W-1:0]             cpuWord, dmaWord;
  logic [2*OFF_W-1:0]            unusedLowBits;
  logic [PORTS-1:0]              portWe, portRvalid;
  logic [PORTS-1:0][WORD_W-1:0]  portWord;
  logic [PORTS-1:0][DATA_W-1:0]  portWdata, portRdata;
  logic [PORTS-1:0][STRB_W-1:0]  portBe;

  assign cpuWord       = cpuAddr[ADDR_W-1:OFF_W];
  assign dmaWord       = dmaAddr[ADDR_W-1:OFF_W];
  assign unusedLowBits = {cpuAddr[OFF_W-1:0], dmaAddr[OFF_W-1:0]};

  assign portWe[CPU_IDX]    = cpuWe;
  assign portWe[DMA_IDX]    = dmaWe;
  assign portWord[CPU_IDX]  = cpuWord;
  assign portWord[DMA_IDX]  = dmaWord;
  assign portWdata[CPU_IDX] = cpuWdata;
  assign portWdata[DMA_IDX] = dmaWdata;
  assign portBe[CPU_IDX]    = cpuBe;
  assign portBe[DMA_IDX]    = dmaBe;

  word_arb_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .cpuWord (cpuWord),
    .dmaReq  (dmaReq),
    .dmaWe   (dmaWe),
    .dmaWord (dmaWord),
    .grant   (grant)
  );

  word_arb_dpath #(.WORD_W(WORD_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .grant      (grant),
    .portWe     (portWe),
    .portWord   (portWord),
    .portWdata  (portWdata),
    .portBe     (portBe),
    .portRvalid (portRvalid),
    .portRdata  (portRdata)
  );

  assign cpuReady  = grant.cpuGo;
  assign dmaReady  = grant.dmaGo;
  assign cpuRvalid = portRvalid[CPU_IDX];
  assign dmaRvalid = portRvalid[DMA_IDX];
  assign cpuRdata  = portRdata[CPU_IDX];
  assign dmaRdata  = portRdata[DMA_IDX];

endmodule

// File: tb/dual_master_word_arb_bench.sv
module dual_master_word_arb_bench;

  typedef struct packed {
    logic        req;
    logic        we;
    logic [11:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
  } op_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0, dmaReq = 1'b0, dmaWe = 1'b0;
  logic [11:0] cpuAddr = '0, dmaAddr = '0;
  logic [63:0] cpuWdata = '0, dmaWdata = '0;
  logic [7:0]  cpuBe = '0, dmaBe = '0;
  logic        cpuReady, dmaReady, cpuRvalid, dmaRvalid;
  logic [63:0] cpuRdata, dmaRdata;

  int          checks = 0;
  int          fails  = 0;
  bit          finished = 1'b0;
  logic [63:0] shadow [512];
  logic [63:0] cpuQ [$];
  logic [63:0] dmaQ [$];
  string       cpuTagQ [$];
  string       dmaTagQ [$];

  always #5 clk = ~clk;

  dual_master_word_arb u_dual_master_word_arb (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuBe(cpuBe), .cpuReady(cpuReady), .cpuRvalid(cpuRvalid), .cpuRdata(cpuRdata),
    .dmaReq(dmaReq), .dmaWe(dmaWe), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata),
    .dmaBe(dmaBe), .dmaReady(dmaReady), .dmaRvalid(dmaRvalid), .dmaRdata(dmaRdata)
  );

  function automatic op_t rd(logic [11:0] a);
    return '{req: 1'b1, we: 1'b0, addr: a, data: '0, be: '0};
  endfunction

  function automatic op_t wr(logic [11:0] a, logic [63:0] d, logic [7:0] b);
    return '{req: 1'b1, we: 1'b1, addr: a, data: d, be: b};
  endfunction

  function automatic op_t idle();
    return '{req: 1'b0, we: 1'b0, addr: '0, data: '0, be: '0};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Byte-lane merge per R6: strobe bit i covers bits 8i+7..8i.
  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, logic [7:0] b);
    logic [63:0] r = old;
    for (int i = 0; i < 8; i++) if (b[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  // Driver: one cycle, expected readiness given from the requirements.
  task automatic step(op_t c, op_t d, bit expC, bit expD, string tag);
    cpuReq = c.req; cpuWe = c.we; cpuAddr = c.addr; cpuWdata = c.data; cpuBe = c.be;
    dmaReq = d.req; dmaWe = d.we; dmaAddr = d.addr; dmaWdata = d.data; dmaBe = d.be;
    #1;
    check(cpuReady == expC, tag, "cpuReady", {63'd0, cpuReady}, {63'd0, expC});
    check(dmaReady == expD, tag, "dmaReady", {63'd0, dmaReady}, {63'd0, expD});
    if (expC && c.req && !c.we) begin cpuQ.push_back(shadow[c.addr[11:3]]); cpuTagQ.push_back(tag); end
    if (expD && d.req && !d.we) begin dmaQ.push_back(shadow[d.addr[11:3]]); dmaTagQ.push_back(tag); end
    if (expD && d.req && d.we) shadow[d.addr[11:3]] = merge(shadow[d.addr[11:3]], d.data, d.be);
    if (expC && c.req && c.we) shadow[c.addr[11:3]] = merge(shadow[c.addr[11:3]], c.data, c.be);
    @(negedge clk);
  endtask

  // Monitor: pops expected read data as rvalid pulses appear (R6).
  always @(negedge clk) begin
    if (rstN) begin
      if (cpuRvalid) begin
        if (cpuQ.size() == 0) check(1'b0, "R6", "cpu stray rvalid", cpuRdata, '0);
        else begin
          logic [63:0] e;
          string t;
          e = cpuQ.pop_front(); t = cpuTagQ.pop_front();
          check(cpuRdata === e, t, "cpuRdata", cpuRdata, e);
        end
      end
      if (dmaRvalid) begin
        if (dmaQ.size() == 0) check(1'b0, "R6", "dma stray rvalid", dmaRdata, '0);
        else begin
          logic [63:0] e;
          string t;
          e = dmaQ.pop_front(); t = dmaTagQ.pop_front();
          check(dmaRdata === e, t, "dmaRdata", dmaRdata, e);
        end
      end
    end
  end

  initial begin
    #200us;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check({cpuReady, dmaReady, cpuRvalid, dmaRvalid} == 4'b0, "R7", "reset outputs",
          {60'd0, cpuReady, dmaReady, cpuRvalid, dmaRvalid}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // Preload, different words, both writes (R2)
    step(wr(12'h000, 64'h0011223344556677, 8'hff), wr(12'h008, 64'h8899aabbccddeeff, 8'hff), 1, 1, "R2");
    step(wr(12'h010, 64'h0123456789abcdef, 8'hff), wr(12'h018, 64'hfedcba9876543210, 8'hff), 1, 1, "R2");
    step(wr(12'h020, 64'h1111111111111111, 8'hff), wr(12'h028, 64'h2222222222222222, 8'hff), 1, 1, "R2");
    // Two reads on different words
    step(rd(12'h000), rd(12'h008), 1, 1, "R2");
    // Neighbouring words: no clash (R1)
    step(rd(12'h010), wr(12'h018, 64'h00000000a5a5a5a5, 8'h0f), 1, 1, "R1");
    // DMA write vs CPU read, same word via low-bit offset (R1, R3)
    step(rd(12'h010), wr(12'h014, 64'hdeadbeef00000000, 8'hf0), 0, 1, "R3");
    step(rd(12'h010), idle(), 1, 0, "R4");
    // CPU write vs DMA read, same word
    step(wr(12'h003, 64'h000000000000c0de, 8'h03), rd(12'h006), 1, 0, "R3");
    step(idle(), rd(12'h006), 0, 1, "R4");
    // Both read the same word: no stall
    step(rd(12'h008), rd(12'h00f), 1, 1, "R2");
    // Both write the same word, overlapping strobes (R5)
    step(wr(12'h020, 64'haaaaaaaaaaaaaaaa, 8'h0f), wr(12'h021, 64'hbbbbbbbbbbbbbbbb, 8'h3c), 0, 1, "R5");
    step(wr(12'h020, 64'haaaaaaaaaaaaaaaa, 8'h0f), idle(), 1, 0, "R5");
    step(rd(12'h020), idle(), 1, 0, "R5");
    // Held-back port keeps priority against a new colliding write (R8)
    step(rd(12'h018), wr(12'h018, 64'h5555555555555555, 8'hff), 0, 1, "R3");
    step(rd(12'h018), wr(12'h01c, 64'h6666666666666666, 8'h0f), 1, 0, "R8");
    step(idle(), wr(12'h01c, 64'h6666666666666666, 8'h0f), 0, 1, "R8");
    step(rd(12'h018), rd(12'h019), 1, 1, "R8");
    // Same word in different cycles never clashes (R2)
    step(wr(12'h028, 64'h7777777777777777, 8'h80), idle(), 1, 0, "R2");
    step(idle(), rd(12'h028), 0, 1, "R2");
    // No request, no ready (R7)
    step(idle(), idle(), 0, 0, "R7");
    step(idle(), idle(), 0, 0, "R7");
    repeat (2) @(negedge clk);
    check(cpuQ.size() == 0 && dmaQ.size() == 0, "R6", "pending reads",
          64'(cpuQ.size() + dmaQ.size()), '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule